// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider

This block divides one 32-bit single-precision floating-point value (the dividend) by another (the divisor). It is fully pipelined. A new operand pair enters on every cycle in which the clock enable is high. The rounded quotient comes out exactly 55 enabled cycles later, together with five exception flags: overflow, underflow, zero, NaN and divide-by-zero.

The result sign and the unbiased exponent difference are computed when the operands enter. The 24-bit significands are then divided by a restoring radix-2 divider that settles one quotient bit per stage over 26 stages. A padding delay line follows, and then a final stage normalizes, rounds to nearest-even, clamps the exponent and packs the result. When the clock enable is low, every pipeline register holds its value. Reset is asynchronous and active-low. It empties the pipeline, so the outputs stay at zero until the first operand pair captured after reset has reached the output.

Top module: `fpdiv_core`

## Requirements
- R1: For normal, non-special operands, the result is the quotient rounded to nearest with ties to even, and all five flags are 0.
- R2: The sign bit (bit 31) of every non-NaN result is the XOR of the two operand sign bits.
- R3: A pair applied at an enabled clock edge produces its result and flags just after the 55th enabled edge, counting the capture edge. A new pair may be applied at every enabled edge.
- R4: While `ce_i` is low, all outputs and all internal stages hold their values, and the operands on the inputs are ignored.
- R5: While `rst_ni` is low, every output is 0. After reset is released, the outputs stay 0 until the first pair captured after reset arrives.
- R6: If either operand is a NaN (exponent 255 with a non-zero fraction), or the operation is 0/0 or inf/inf, the result is 0x7FC00000 and only `nan_o` is set.
- R7: A finite, non-zero dividend divided by zero gives an infinity (exponent 255, fraction 0) carrying the XOR sign, and only `div_by_zero_o` is set.
- R8: An infinite dividend with a finite divisor (zero included) gives a signed infinity, and no flag is set.
- R9: A zero dividend with a non-zero divisor, or a finite dividend with an infinite divisor, gives a signed zero, and only `zero_o` is set.
- R10: When the biased exponent after rounding exceeds 254, the result is a signed infinity and only `overflow_o` is set.
- R11: When the biased exponent after rounding is below 1, the result is a signed zero, and only `underflow_o` and `zero_o` are set.
- R12: An operand whose exponent field is 0 is treated as zero, whatever its fraction bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable, active high; low stalls the whole pipeline |
| dividend_i | input | 32 | Dividend, single precision |
| divisor_i | input | 32 | Divisor, single precision |
| result_o | output | 32 | Quotient, single precision |
| overflow_o | output | 1 | Result overflowed to infinity |
| underflow_o | output | 1 | Result flushed to zero because the exponent was too small |
| zero_o | output | 1 | Result is zero |
| nan_o | output | 1 | Result is the quiet NaN |
| div_by_zero_o | output | 1 | Finite non-zero value divided by zero |

## Verification
The output-side assertions assume that the final stage raises at most one exception class per result. They also assume that a stall cycle gives the output register no load. Both hold for any operand bits, so the stimulus never needs to avoid an encoding. The stall assertion also assumes that `ce_i` changes only away from the clock edge. The bench keeps to this by driving `ce_i` and the operands only on the falling edge. It releases reset one time unit after a falling edge, so the first enabled capture is always a clean rising edge.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
  localparam int EXP_W   = 8;
  localparam int MANT_W  = 23;
  localparam int SIG_W   = MANT_W + 1;       // significand with hidden one
  localparam int Q_BITS  = SIG_W + 2;        // quotient bits: hidden, 23 frac, guard, spare
  localparam int REM_W   = Q_BITS;
  localparam int EXPI_W  = EXP_W + 2;        // signed internal exponent
  localparam int BIAS    = 127;
  localparam int EXP_MAX = 254;

  typedef enum logic [2:0] {
    K_NORM = 3'd0,
    K_NAN  = 3'd1,
    K_INF  = 3'd2,
    K_DBZ  = 3'd3,
    K_ZERO = 3'd4
  } kind_e;

  typedef struct packed {
    logic                     valid;
    logic                     sign;
    logic signed [EXPI_W-1:0] exp;
    kind_e                    kind;
    logic [Q_BITS-1:0]        quo;
    logic [REM_W-1:0]         rem;
    logic [SIG_W-1:0]         dvs;
  } slot_t;
endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack
  import fpdiv_pkg::*;
(
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  output slot_t       slot_o
);
  logic [EXP_W-1:0]  ea, eb;
  logic [MANT_W-1:0] fa, fb;
  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;

  assign ea = a_i[30:23];
  assign eb = b_i[30:23];
  assign fa = a_i[22:0];
  assign fb = b_i[22:0];

  // denormals collapse to zero
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == '1) && (fa == '0);
  assign b_inf  = (eb == '1) && (fb == '0);
  assign a_nan  = (ea == '1) && (fa != '0);
  assign b_nan  = (eb == '1) && (fb != '0);

  always_comb begin
    slot_o       = '0;
    slot_o.valid = 1'b1;
    slot_o.sign  = a_i[31] ^ b_i[31];
    slot_o.exp   = $signed({2'b00, ea}) - $signed({2'b00, eb}) + EXPI_W'(BIAS);
    slot_o.rem   = REM_W'({1'b1, fa});
    slot_o.dvs   = {1'b1, fb};
    if (a_nan || b_nan || (a_zero && b_zero) || (a_inf && b_inf))
      slot_o.kind = K_NAN;
    else if (a_inf)
      slot_o.kind = K_INF;
    else if (b_zero)
      slot_o.kind = K_DBZ;
    else if (a_zero || b_inf)
      slot_o.kind = K_ZERO;
    else
      slot_o.kind = K_NORM;
  end
endmodule

// File: rtl/fpdiv_div_step.sv
module fpdiv_div_step
  import fpdiv_pkg::*;
(
  input  slot_t slot_i,
  output slot_t slot_o
);
  logic             fits;
  logic [REM_W-1:0] diff;
  logic [REM_W-1:0] kept;

  assign fits = slot_i.rem >= REM_W'(slot_i.dvs);
  assign diff = slot_i.rem - REM_W'(slot_i.dvs);
  assign kept = fits ? diff : slot_i.rem;

  always_comb begin
    slot_o     = slot_i;
    slot_o.quo = {slot_i.quo[Q_BITS-2:0], fits};
    slot_o.rem = {kept[REM_W-2:0], 1'b0};
  end
endmodule

// File: rtl/fpdiv_pack.sv
module fpdiv_pack
  import fpdiv_pkg::*;
(
  input  slot_t       slot_i,
  output logic [31:0] result_o,
  output logic        ovf_o,
  output logic        unf_o,
  output logic        zero_o,
  output logic        nan_o,
  output logic        dbz_o
);
  logic                     hi;
  logic [SIG_W-1:0]         mant;
  logic                     guard, sticky, rnd;
  logic [SIG_W:0]           msum;
  logic [SIG_W-1:0]         mfin;
  logic signed [EXPI_W-1:0] e1, e2;

  assign hi     = slot_i.quo[Q_BITS-1];
  assign mant   = hi ? slot_i.quo[Q_BITS-1:2] : slot_i.quo[Q_BITS-2:1];
  assign guard  = hi ? slot_i.quo[1] : slot_i.quo[0];
  assign sticky = (hi & slot_i.quo[0]) | (|slot_i.rem);
  assign rnd    = guard & (sticky | mant[0]);
  assign msum   = {1'b0, mant} + (SIG_W+1)'(rnd);
  assign mfin   = msum[SIG_W] ? msum[SIG_W:1] : msum[SIG_W-1:0];
  assign e1     = hi ? slot_i.exp : slot_i.exp - EXPI_W'(1);
  assign e2     = e1 + EXPI_W'(msum[SIG_W]);

  always_comb begin
    result_o = '0;
    ovf_o = 1'b0; unf_o = 1'b0; zero_o = 1'b0; nan_o = 1'b0; dbz_o = 1'b0;
    unique case (slot_i.kind)
      K_NAN:  begin result_o = 32'h7FC0_0000; nan_o = 1'b1; end
      K_INF:  result_o = {slot_i.sign, 8'hFF, 23'd0};
      K_DBZ:  begin result_o = {slot_i.sign, 8'hFF, 23'd0}; dbz_o = 1'b1; end
      K_ZERO: begin result_o = {slot_i.sign, 31'd0}; zero_o = 1'b1; end
      default: begin
        if (e2 > EXPI_W'(EXP_MAX)) begin
          result_o = {slot_i.sign, 8'hFF, 23'd0};
          ovf_o    = 1'b1;
        end else if (e2 < EXPI_W'(1)) begin
          result_o = {slot_i.sign, 31'd0};
          unf_o    = 1'b1;
          zero_o   = 1'b1;
        end else begin
          result_o = {slot_i.sign, e2[EXP_W-1:0], mfin[MANT_W-1:0]};
        end
      end
    endcase
  end
endmodule

// File: rtl/fpdiv_core.sv
module fpdiv_core
  import fpdiv_pkg::*;
#(
  parameter int LATENCY = 55
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_i,
  input  logic [31:0] dividend_i,
  input  logic [31:0] divisor_i,
  output logic [31:0] result_o,
  output logic        overflow_o,
  output logic        underflow_o,
  output logic        zero_o,
  output logic        nan_o,
  output logic        div_by_zero_o
);
  // capture stage + Q_BITS divider stages + PAD delay + output register
  localparam int PAD = LATENCY - Q_BITS - 2;

  slot_t in_slot, s0_q, tail;
  slot_t div_d [Q_BITS];
  slot_t div_q [Q_BITS];

  logic [31:0] res_d;
  logic        ovf_d, unf_d, zero_d, nan_d, dbz_d;

  fpdiv_unpack u_unpack (.a_i(dividend_i), .b_i(divisor_i), .slot_o(in_slot));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   s0_q <= '0;
    else if (ce_i) s0_q <= in_slot;
  end

  for (genvar k = 0; k < Q_BITS; k++) begin : g_step
    if (k == 0) begin : g_first
      fpdiv_div_step u_step (.slot_i(s0_q), .slot_o(div_d[k]));
    end else begin : g_next
      fpdiv_div_step u_step (.slot_i(div_q[k-1]), .slot_o(div_d[k]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < Q_BITS; k++) div_q[k] <= '0;
    end else if (ce_i) begin
      for (int k = 0; k < Q_BITS; k++) div_q[k] <= div_d[k];
    end
  end

  if (PAD > 0) begin : g_pad
    slot_t dly_q [PAD];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < PAD; k++) dly_q[k] <= '0;
      end else if (ce_i) begin
        dly_q[0] <= div_q[Q_BITS-1];
        for (int k = 1; k < PAD; k++) dly_q[k] <= dly_q[k-1];
      end
    end
    assign tail = dly_q[PAD-1];
  end else begin : g_nopad
    assign tail = div_q[Q_BITS-1];
  end

  fpdiv_pack u_pack (
    .slot_i(tail), .result_o(res_d), .ovf_o(ovf_d), .unf_o(unf_d),
    .zero_o(zero_d), .nan_o(nan_d), .dbz_o(dbz_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0; overflow_o <= 1'b0; underflow_o <= 1'b0;
      zero_o <= 1'b0; nan_o <= 1'b0; div_by_zero_o <= 1'b0;
    end else if (ce_i) begin
      result_o      <= tail.valid ? res_d : '0;
      overflow_o    <= tail.valid & ovf_d;
      underflow_o   <= tail.valid & unf_d;
      zero_o        <= tail.valid & zero_d;
      nan_o         <= tail.valid & nan_d;
      div_by_zero_o <= tail.valid & dbz_d;
    end
  end

  AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nan_o |-> (result_o == 32'h7FC0_0000) && !zero_o && !overflow_o); // R6
  AST_DBZ_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_by_zero_o |-> (result_o[30:0] == 31'h7F80_0000) && !nan_o && !overflow_o); // R7
  AST_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (result_o[30:0] == 31'h7F80_0000) && !underflow_o); // R10
  AST_UNF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> zero_o && (result_o[30:0] == 31'd0)); // R11
  AST_ZERO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (result_o[30:0] == 31'd0)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(result_o) && $stable(zero_o) && $stable(nan_o)); // R4
endmodule

// File: tb/fpdiv_core_tb.sv
module fpdiv_core_tb;
  localparam int LAT = 55;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] result;
  logic        ovf, unf, zro, nan, dbz;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    done    = 1'b0;
  string phase   = "R1";

  logic [36:0] exp_q [$];
  logic [36:0] expect_v = '0;

  always #2 clk = ~clk;

  fpdiv_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .dividend_i(a), .divisor_i(b),
    .result_o(result), .overflow_o(ovf), .underflow_o(unf), .zero_o(zro),
    .nan_o(nan), .div_by_zero_o(dbz)
  );

  // {ovf, unf, zero, nan, dbz, result}
  function automatic logic [36:0] ref_div(logic [31:0] x, logic [31:0] y);
    int ex, ey, e;
    logic [22:0] fx, fy;
    logic sg;
    longint mx, my, num, q, r, m;
    bit xz, yz, xi, yi, xn, yn, g, st;
    ex = int'(x[30:23]); ey = int'(y[30:23]);
    fx = x[22:0]; fy = y[22:0];
    sg = x[31] ^ y[31];
    xz = (ex == 0); yz = (ey == 0);
    xi = (ex == 255) && (fx == 0); yi = (ey == 255) && (fy == 0);
    xn = (ex == 255) && (fx != 0); yn = (ey == 255) && (fy != 0);
    if (xn || yn || (xz && yz) || (xi && yi)) return {5'b00010, 32'h7FC0_0000};
    if (xi) return {5'b00000, sg, 8'hFF, 23'd0};
    if (yz) return {5'b00001, sg, 8'hFF, 23'd0};
    if (xz || yi) return {5'b00100, sg, 31'd0};
    mx = longint'({1'b1, fx}); my = longint'({1'b1, fy});
    num = mx * (64'd1 << 25);
    q = num / my; r = num % my;
    e = ex - ey + 127;
    if (q >= (64'd1 << 25)) begin
      m = q / 4; g = q[1]; st = q[0] || (r != 0);
    end else begin
      e = e - 1; m = q / 2; g = q[0]; st = (r != 0);
    end
    if (g && (st || m[0])) m = m + 1;
    if (m == (64'd1 << 24)) begin m = 64'd1 << 23; e = e + 1; end
    if (e > 254) return {5'b10000, sg, 8'hFF, 23'd0};
    if (e < 1)   return {5'b01100, sg, 31'd0};
    return {5'b00000, sg, 8'(e), m[22:0]};
  endfunction

  // reference pipeline: advances on enabled edges only
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      expect_v <= '0;
    end else if (ce) begin
      exp_q.push_back(ref_div(a, b));
      if (exp_q.size() == LAT) expect_v <= exp_q.pop_front();
    end
  end

  function automatic string tag_of(logic [36:0] e, logic [36:0] got);
    if (e[33])      return "R6";
    if (e[32])      return "R7";
    if (e[36])      return "R10";
    if (e[35])      return "R11";
    if (e[34])      return "R9";
    if (e[30:23] == 8'hFF) return "R8";
    if (got[31] != e[31])  return "R2";
    return "R1";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [36:0] got;
      got = {ovf, unf, zro, nan, dbz, result};
      n_tests++;
      if (got !== expect_v) begin
        n_fail++;
        $display("FAIL %s/%s a=%h b=%h got=%h expected=%h", tag_of(expect_v, got),
                 phase, a, b, got, expect_v);
      end
    end
  end

  task automatic check_zero(string tag);
    n_tests++;
    if ({ovf, unf, zro, nan, dbz, result} !== 37'd0) begin
      n_fail++;
      $display("FAIL %s got=%h expected=0", tag, {ovf, unf, zro, nan, dbz, result});
    end
  endtask

  task automatic drive(logic [31:0] x, logic [31:0] y, logic en);
    @(negedge clk);
    a = x; b = y; ce = en;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check_zero("R5");
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  logic [31:0] specials [12];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    specials = '{32'h0000_0000, 32'h8000_0000, 32'h0000_1234, 32'h7F80_0000,
                 32'hFF80_0000, 32'h7FC0_0000, 32'h7F80_0001, 32'h3F80_0000,
                 32'hC020_0000, 32'h7F7F_FFFF, 32'h0080_0000, 32'h8040_0001};
    check_zero("R5");
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 rst_n = 1'b1;
    #1 check_zero("R5");

    phase = "R3";
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      if (x[30:23] == 8'hFF) x[30] = 1'b0;
      if (y[30:23] == 8'hFF) y[30] = 1'b0;
      drive(x, y, 1'b1);
    end

    phase = "R12";
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++) drive(specials[i], specials[j], 1'b1);

    phase = "R1";
    drive(32'h3F80_0000, 32'h4040_0000, 1'b1);
    drive(32'h4120_0000, 32'h40A0_0000, 1'b1);
    drive(32'h7F00_0000, 32'h0080_0000, 1'b1);
    drive(32'h0080_0000, 32'h7F00_0000, 1'b1);
    drive(32'h3F7F_FFFF, 32'h3F80_0001, 1'b1);
    drive(32'h0100_0000, 32'h3FFF_FFFF, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = {1'($urandom), 8'($urandom_range(1, 254)), 23'($urandom)};
      y = {1'($urandom), 8'($urandom_range(1, 254)), 23'($urandom)};
      drive(x, y, 1'b1);
    end

    phase = "R4";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] x, y;
      x = {1'($urandom), 8'($urandom_range(60, 200)), 23'($urandom)};
      y = (i % 7 == 0) ? specials[i % 12] : {1'($urandom), 8'($urandom_range(60, 200)), 23'($urandom)};
      drive(x, y, ($urandom % 3) != 0);
    end
    drive(32'h4000_0000, 32'h3F80_0000, 1'b1);
    for (int i = 0; i < 70; i++) drive($urandom, $urandom, 1'b0);
    for (int i = 0; i < LAT + 5; i++) drive(32'h3F80_0000, 32'h3F80_0000, 1'b1);

    phase = "R5";
    do_reset();
    #1 check_zero("R5");
    phase = "R3";
    drive(32'h40C0_0000, 32'h4000_0000, 1'b1);
    for (int i = 0; i < LAT + 10; i++) drive(32'h0, 32'h3F80_0000, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule